// File: doc/BRIEF.md
# Link Equalization Phase Controller

This block sequences transmitter equalization when a serial link is asked to move to a third-generation or faster rate. A start request carries the target generation. Targets below three raise the rate at once and skip equalization. Higher targets run four phases in a fixed order. Phase 0 takes the transmitter preset index that the downstream side asks for. Phase 1 raises the rate and waits for the first training result. Phase 2 tunes the upstream port and phase 3 tunes the downstream port.

During each tuning phase the controller offers candidate preset indices in rising order, starting at 0. It keeps the first one whose error-rate flag says the link is better than one error in 10^12 bits. The local port role decides which tuning phase drives this port's own active preset. In the other tuning phase the controller scores the partner's candidates and leaves its own preset unchanged. Three things make the controller fail and withdraw the rate request: an out-of-range preset, a sweep that runs out of candidates, and a phase that stalls past the timeout.

Top module: `leq_phase_ctrl`

## Requirements
- R1: After synchronous reset, phase_o is 0 (idle), active_preset_o is 0, and rate_req_o, done_o and fail_o are 0.
- R2: A start from idle, done or fail with tgt_gen_i of 1 or 2 moves phase_o to 5 (done) one cycle later, with rate_req_o 1 and no equalization phase visited.
- R3: A start with tgt_gen_i of 3 or more moves phase_o to 1 (phase 0) one cycle later. A start while phase_o is 1 to 4 has no effect.
- R4: Phase 0 lasts one cycle. req_preset_i is sampled at the edge that ends it. A value of 11 or more sends phase_o to 6 (fail) with rate_req_o 0. A value of 0 to 10 becomes active_preset_o, and phase_o goes to 2 (phase 1) with rate_req_o 1.
- R5: In phase 1 the controller waits for eval_valid_i and moves to phase_o 3 (phase 2) on the edge where it is seen.
- R6: In phases 2 and 3 each eval_valid_i pulse scores one candidate, taken in the order 0, 1, 2 and so on. The first pulse with ber_good_i 1 keeps that candidate. The phase then advances: phase 2 goes to phase_o 4, and phase 3 goes to phase_o 5 (done) with rate_req_o still 1.
- R7: With role_down_i 0 (upstream) the port's own tuning phase is phase 2. With role_down_i 1 (downstream) it is phase 3. In the own phase, active_preset_o shows the candidate under trial and afterwards keeps the accepted one. In the other tuning phase it holds its previous value.
- R8: A bad score for candidate 10 sends phase_o to 6 (fail) and drops rate_req_o.
- R9: If phase 1, 2 or 3 lasts TIMEOUT cycles without advancing, phase_o goes to 6 (fail) on that edge and rate_req_o drops. After TIMEOUT-1 such cycles the phase is unchanged.
- R10: Phases follow the strict order 0, 1, 2, 3. The only other exit from a phase is to fail.
- R11: A start from done or fail restarts the sequence. For a target of 3 or more it clears rate_req_o until phase 0 completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| tgt_gen_i | input | 3 | Target rate generation for the start |
| role_down_i | input | 1 | 1 = downstream port, 0 = upstream port |
| req_preset_i | input | 4 | Preset index requested in phase 0 |
| eval_valid_i | input | 1 | One candidate preset evaluation finished |
| ber_good_i | input | 1 | Evaluated error rate meets the 10^-12 target |
| phase_o | output | 3 | 0 idle, 1-4 phase 0-3, 5 done, 6 fail |
| active_preset_o | output | 4 | Local transmitter preset |
| rate_req_o | output | 1 | Raised-rate request |
| done_o | output | 1 | Sequence completed |
| fail_o | output | 1 | Sequence failed |

## Verification
Every result except the timeout is due one clock edge after its stimulus. The start, the phase 0 preset and each evaluation pulse all update phase_o, active_preset_o and rate_req_o on the next rising edge. The timeout fails exactly TIMEOUT edges after entry into phase 1, 2 or 3. The driver holds each stimulus for one full cycle, from one falling edge to the next, and queues the values it expects. The monitor compares them one time unit after that following falling edge, and the timeout case is probed at TIMEOUT-1 and TIMEOUT cycles.

// File: rtl/leq_pkg.sv
package leq_pkg;

    parameter int PRESET_W = 4;
    parameter int GEN_W    = 3;
    parameter logic [PRESET_W-1:0] PRESET_MAX  = PRESET_W'(10);
    parameter logic [GEN_W-1:0]    EQ_MIN_GEN  = GEN_W'(3);

    typedef enum logic [2:0] {
        EQ_IDLE = 3'd0,
        EQ_PH0  = 3'd1,
        EQ_PH1  = 3'd2,
        EQ_PH2  = 3'd3,
        EQ_PH3  = 3'd4,
        EQ_DONE = 3'd5,
        EQ_FAIL = 3'd6
    } eq_state_e;

    typedef struct packed {
        logic valid;
        logic good;
    } eval_s;

    function automatic logic preset_ok(input logic [PRESET_W-1:0] p);
        return p <= PRESET_MAX;
    endfunction

    function automatic logic is_busy(input eq_state_e s);
        return (s == EQ_PH0) || (s == EQ_PH1) || (s == EQ_PH2) || (s == EQ_PH3);
    endfunction

endpackage

// File: rtl/leq_phase_timer.sv
module leq_phase_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_TMO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !expired) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R9

endmodule

// File: rtl/leq_cand_sweep.sv
module leq_cand_sweep #(
    parameter int W = 4,
    parameter logic [W-1:0] PMAX = W'(10)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cand,
    output logic         last
);
    logic [W-1:0] cand_q;

    assign cand = cand_q;
    assign last = (cand_q == PMAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cand_q <= '0;
        end else if (step && !last) begin
            cand_q <= cand_q + W'(1);
        end
    end

    AST_CAND_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && !last) |=> (cand_q == $past(cand_q) + W'(1))); // R6

    AST_CAND_RANGE: assert property (@(posedge clk) disable iff (rst)
        cand_q <= PMAX); // R4

endmodule

// File: rtl/leq_phase_ctrl.sv
module leq_phase_ctrl
    import leq_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [GEN_W-1:0]    tgt_gen_i,
    input  logic                role_down_i,
    input  logic [PRESET_W-1:0] req_preset_i,
    input  logic                eval_valid_i,
    input  logic                ber_good_i,
    output logic [2:0]          phase_o,
    output logic [PRESET_W-1:0] active_preset_o,
    output logic                rate_req_o,
    output logic                done_o,
    output logic                fail_o
);
    eq_state_e           state_q, state_d;
    logic [PRESET_W-1:0] held_q, held_d;
    logic                rate_q, rate_d;
    eval_s               ev;
    logic                tuning, in_own, tmo_en, tmo_hit, phase_chg;
    logic                cand_step, cand_last;
    logic [PRESET_W-1:0] cand;
    eq_state_e           own_phase;

    assign ev.valid  = eval_valid_i;
    assign ev.good   = ber_good_i;
    assign tuning    = (state_q == EQ_PH2) || (state_q == EQ_PH3);
    assign own_phase = role_down_i ? EQ_PH3 : EQ_PH2;
    assign in_own    = (state_q == own_phase);
    assign tmo_en    = (state_q == EQ_PH1) || tuning;
    assign phase_chg = (state_d != state_q);
    assign cand_step = tuning && ev.valid && !ev.good;

    leq_phase_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_chg),
        .en      (tmo_en),
        .expired (tmo_hit)
    );

    leq_cand_sweep #(.W(PRESET_W), .PMAX(PRESET_MAX)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .clr  (phase_chg),
        .step (cand_step),
        .cand (cand),
        .last (cand_last)
    );

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        rate_d  = rate_q;
        unique case (state_q)
            EQ_IDLE, EQ_DONE, EQ_FAIL: begin
                if (start_i) begin
                    if (tgt_gen_i >= EQ_MIN_GEN) begin
                        state_d = EQ_PH0;
                        rate_d  = 1'b0;
                    end else begin
                        state_d = EQ_DONE;
                        rate_d  = 1'b1;
                    end
                end
            end
            EQ_PH0: begin
                if (preset_ok(req_preset_i)) begin
                    state_d = EQ_PH1;
                    held_d  = req_preset_i;
                    rate_d  = 1'b1;
                end else begin
                    state_d = EQ_FAIL;
                end
            end
            EQ_PH1: begin
                if (ev.valid) begin
                    state_d = EQ_PH2;
                end else if (tmo_hit) begin
                    state_d = EQ_FAIL;
                end
            end
            EQ_PH2, EQ_PH3: begin
                if (ev.valid && ev.good) begin
                    state_d = (state_q == EQ_PH2) ? EQ_PH3 : EQ_DONE;
                    if (in_own) begin
                        held_d = cand;
                    end
                end else if (ev.valid && cand_last) begin
                    state_d = EQ_FAIL;
                end else if (!ev.valid && tmo_hit) begin
                    state_d = EQ_FAIL;
                end
            end
            default: state_d = EQ_IDLE;
        endcase
        if (state_d == EQ_FAIL) begin
            rate_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EQ_IDLE;
            held_q  <= '0;
            rate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
            rate_q  <= rate_d;
        end
    end

    assign phase_o         = state_q;
    assign active_preset_o = in_own ? cand : held_q;
    assign rate_req_o      = rate_q;
    assign done_o          = (state_q == EQ_DONE);
    assign fail_o          = (state_q == EQ_FAIL);

    AST_ORDER_PH0: assert property (@(posedge clk) disable iff (rst)
        (state_q == EQ_PH0) |=> (state_q == EQ_PH1 || state_q == EQ_FAIL)); // R10
    AST_ORDER_PH1: assert property (@(posedge clk) disable iff (rst)
        (state_q == EQ_PH1) |=> (state_q == EQ_PH1 || state_q == EQ_PH2 || state_q == EQ_FAIL)); // R10
    AST_ORDER_PH2: assert property (@(posedge clk) disable iff (rst)
        (state_q == EQ_PH2) |=> (state_q == EQ_PH2 || state_q == EQ_PH3 || state_q == EQ_FAIL)); // R10
    AST_ORDER_PH3: assert property (@(posedge clk) disable iff (rst)
        (state_q == EQ_PH3) |=> (state_q == EQ_PH3 || state_q == EQ_DONE || state_q == EQ_FAIL)); // R10
    AST_FAIL_NO_RATE: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> !rate_req_o); // R8
    AST_NO_RATE_PH0: assert property (@(posedge clk) disable iff (rst)
        (state_q == EQ_PH0) |-> !rate_req_o); // R4
    AST_PRESET_RANGE: assert property (@(posedge clk) disable iff (rst)
        active_preset_o <= PRESET_MAX); // R4
    AST_LOW_GEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (!is_busy(state_q) && start_i && tgt_gen_i < EQ_MIN_GEN) |=> (done_o && rate_req_o)); // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (is_busy(state_q) && start_i) |=> (state_q != EQ_PH0 || $past(state_q) == EQ_PH0)); // R3

endmodule

// File: tb/leq_phase_ctrl_bench.sv
module leq_phase_ctrl_bench;
    localparam int TMO = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] tgt_gen_i = '0;
    logic       role_down_i = 1'b0;
    logic [3:0] req_preset_i = '0;
    logic       eval_valid_i = 1'b0;
    logic       ber_good_i = 1'b0;
    logic [2:0] phase_o;
    logic [3:0] active_preset_o;
    logic       rate_req_o, done_o, fail_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [2:0] ph;
        logic [3:0] pre;
        logic       rate;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    leq_phase_ctrl #(.TIMEOUT(TMO)) u_leq_phase_ctrl (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .tgt_gen_i       (tgt_gen_i),
        .role_down_i     (role_down_i),
        .req_preset_i    (req_preset_i),
        .eval_valid_i    (eval_valid_i),
        .ber_good_i      (ber_good_i),
        .phase_o         (phase_o),
        .active_preset_o (active_preset_o),
        .rate_req_o      (rate_req_o),
        .done_o          (done_o),
        .fail_o          (fail_o)
    );

    task automatic cyc(input logic st, input logic [2:0] gen, input logic [3:0] pre,
                       input logic ev, input logic good);
        start_i      = st;
        tgt_gen_i    = gen;
        req_preset_i = pre;
        eval_valid_i = ev;
        ber_good_i   = good;
        @(negedge clk);
        start_i      = 1'b0;
        eval_valid_i = 1'b0;
        ber_good_i   = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [2:0] ph,
                              input logic [3:0] pre, input logic rate);
        exp_t it;
        it.tag  = tag;
        it.ph   = ph;
        it.pre  = pre;
        it.rate = rate;
        exp_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t it;
                logic ok;
                it = exp_q.pop_front();
                checks++;
                ok = (phase_o === it.ph) && (active_preset_o === it.pre) &&
                     (rate_req_o === it.rate) && (done_o === (it.ph == 3'd5)) &&
                     (fail_o === (it.ph == 3'd6));
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: actual phase=%0d preset=%0d rate=%0b done=%0b fail=%0b expected phase=%0d preset=%0d rate=%0b",
                             it.tag, phase_o, active_preset_o, rate_req_o, done_o, fail_o,
                             it.ph, it.pre, it.rate);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(0, 3'd0, 4'd0, 0, 0);
        expect_out("R1 reset state", 3'd0, 4'd0, 1'b0);

        // R2: second-generation target skips equalization
        cyc(1, 3'd2, 4'd0, 0, 0);
        expect_out("R2 low gen done", 3'd5, 4'd0, 1'b1);

        // Upstream role: own tuning phase is phase 2
        role_down_i = 1'b0;
        cyc(1, 3'd3, 4'd0, 0, 0);
        expect_out("R3/R11 start from done", 3'd1, 4'd0, 1'b0);
        cyc(0, 3'd3, 4'd7, 0, 0);
        expect_out("R4 preset 7 accepted", 3'd2, 4'd7, 1'b1);
        cyc(1, 3'd3, 4'd0, 0, 0);
        expect_out("R3 start ignored in phase 1", 3'd2, 4'd7, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R5/R10 phase 1 to 2", 3'd3, 4'd0, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R7 own candidate 1", 3'd3, 4'd1, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R6 candidate 2", 3'd3, 4'd2, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 1);
        expect_out("R6/R7 keep 2 enter phase 3", 3'd4, 4'd2, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R7 partner phase holds", 3'd4, 4'd2, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 1);
        expect_out("R6 done", 3'd5, 4'd2, 1'b1);

        // Downstream role: own tuning phase is phase 3
        role_down_i = 1'b1;
        cyc(1, 3'd4, 4'd0, 0, 0);
        expect_out("R11 restart gen4", 3'd1, 4'd2, 1'b0);
        cyc(0, 3'd4, 4'd3, 0, 0);
        expect_out("R4 preset 3", 3'd2, 4'd3, 1'b1);
        cyc(0, 3'd4, 4'd0, 1, 0);
        expect_out("R5 phase 2", 3'd3, 4'd3, 1'b1);
        cyc(0, 3'd4, 4'd0, 1, 1);
        expect_out("R7 downstream own phase 3", 3'd4, 4'd0, 1'b1);
        for (int i = 0; i < 4; i++) cyc(0, 3'd4, 4'd0, 1, 0);
        expect_out("R6/R7 candidate 4", 3'd4, 4'd4, 1'b1);
        cyc(0, 3'd4, 4'd0, 1, 1);
        expect_out("R6/R7 keep 4 done", 3'd5, 4'd4, 1'b1);

        // R4: out-of-range preset
        cyc(1, 3'd3, 4'd0, 0, 0);
        expect_out("R3 start", 3'd1, 4'd4, 1'b0);
        cyc(0, 3'd3, 4'd11, 0, 0);
        expect_out("R4 preset 11 rejected", 3'd6, 4'd4, 1'b0);

        // R8: boundary preset 10 accepted, then sweep exhausted
        cyc(1, 3'd3, 4'd0, 0, 0);
        expect_out("R11 restart from fail", 3'd1, 4'd4, 1'b0);
        cyc(0, 3'd3, 4'd10, 0, 0);
        expect_out("R4 preset 10 accepted", 3'd2, 4'd10, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R5 phase 2", 3'd3, 4'd10, 1'b1);
        for (int i = 0; i < 10; i++) cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R8 candidate 10 pending", 3'd3, 4'd10, 1'b1);
        cyc(0, 3'd3, 4'd0, 1, 0);
        expect_out("R8 sweep exhausted", 3'd6, 4'd10, 1'b0);

        // R9: phase timeout
        cyc(1, 3'd3, 4'd0, 0, 0);
        expect_out("R3 start", 3'd1, 4'd10, 1'b0);
        cyc(0, 3'd3, 4'd5, 0, 0);
        expect_out("R4 preset 5", 3'd2, 4'd5, 1'b1);
        for (int i = 0; i < TMO - 1; i++) cyc(0, 3'd3, 4'd0, 0, 0);
        expect_out("R9 before timeout", 3'd2, 4'd5, 1'b1);
        cyc(0, 3'd3, 4'd0, 0, 0);
        expect_out("R9 timeout fail", 3'd6, 4'd5, 1'b0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule